// File: doc/BRIEF.md
# Set-Associative Cache Tag and Line-State Store

This block holds the address side of a four-way set-associative cache with 256 sets and 32-byte lines. A lookup presents a virtual address and the physical tag produced by address translation. Bits [12:5] of the virtual address choose the set. The physical tag is compared against all four ways of that set in the same cycle. One cycle later the block reports whether a way hit and which one. It also reports the way to replace on a miss, whether that way is dirty, and the longword offset (address bits [4:2]) for the data array.

Each line carries a 19-bit tag, meaning physical address bits [28:10], along with a valid bit and a dirty bit. Each set carries six LRU bits. There is one bit for each pair of ways, and the bit for pair (i, j) with i < j sits at index i*4 - i*(i+1)/2 + (j-i-1). A 1 means way i was used more recently than way j.

A direct write port fills or edits one line's tag, valid bit and dirty bit. Two reset inputs exist. The power-on reset clears line state and recency. The manual reset leaves all stored line state alone and only clears the result registers. Both resets are synchronous and active high. While either is high, lookups and writes are ignored. Tags are never cleared.

Top module: `setassoc_tag_store`

## Requirements
- R1: When no reset is high, `res_valid` in a cycle equals `lk_req` of the previous cycle. After each accepted lookup, `res_lword` equals bits [4:2] of that lookup's `lk_vaddr`.
- R2: A lookup hits in way w only if way w of the set `lk_vaddr[12:5]` is valid and its stored tag equals `lk_ptag`. On a hit, `res_hit` is 1 and `res_way` is w. Otherwise `res_hit` is 0.
- R3: Neither reset clears stored tags. A line whose valid bit is 0 never hits, whatever its stored tag.
- R4: A power-on reset clears every valid bit, every dirty bit and every LRU field to 0, and drops `res_valid` and `res_hit` in the next cycle. After it, a miss names way 0 as victim with `res_victim_dirty` 0.
- R5: A manual reset leaves the valid bits, dirty bits and LRU fields unchanged. It forces `res_valid` to 0 in the next cycle, and a lookup presented during it is ignored.
- R6: A lookup with `lk_store`=1 that hits while `copyback`=1 sets that line's dirty bit to 1.
- R7: A lookup with `lk_store`=1 that hits while `copyback`=0 leaves the dirty bit unchanged. Only the write port changes it then.
- R8: A write-port access (`wr_en`=1) loads the tag, valid bit and dirty bit of the line at (`wr_set`, `wr_way`). When `wr_valid`=1, that way becomes the most recently used way of the set.
- R9: A lookup hit makes the hit way the most recently used way of its set. When all four ways are valid, `res_victim` is the way used least recently, and `res_victim_dirty` is that way's dirty bit.
- R10: When any way of the looked-up set is invalid, `res_victim` is the lowest-numbered invalid way.
- R11: At most one way hits in any lookup.
- R12: A lookup and a write-port access in the same cycle both see the line state from before that cycle. If both touch the same set, the write-port way ends up most recent. If both touch the same line, the write-port values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_ptag | input | 19 | Physical tag from translation (physical bits [28:10]) |
| lk_store | input | 1 | The lookup is a store |
| copyback | input | 1 | 1 = copy-back mode, 0 = write-through mode |
| wr_en | input | 1 | Direct line write enable |
| wr_set | input | 8 | Set written by the write port |
| wr_way | input | 2 | Way written by the write port |
| wr_tag | input | 19 | Tag to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_dirty | input | 1 | Dirty bit to store |
| res_valid | output | 1 | Result registers hold a new lookup result |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 2 | Hit way |
| res_victim | output | 2 | Replacement way for the looked-up set |
| res_victim_dirty | output | 1 | Dirty bit of the replacement way |
| res_lword | output | 3 | Longword select for the data array |

## Verification
Directed sequences fill one set a way at a time, then hit ways in a chosen order. The victim reported on a later miss must then match that order, which separates a true least-recent choice from a fixed or round-robin one. Copy-back stores and write-through stores are applied to twin sets with the same history, so the victim dirty flag shows whether mode gating is correct. Manual-reset and power-on-reset pulses between lookups separate state that must survive from state that must clear. A cycle that looks up and rewrites the same line checks the pre-edge view. A long random mix of lookups, stores and fills over a few sets with a small tag pool then drives frequent hits, invalidations and victim changes against a recency-stamp model.

// File: rtl/sats_pkg.sv
`timescale 1ns/1ps
package sats_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);
  localparam int LRU_W = WAYS * (WAYS - 1) / 2;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [LRU_W-1:0] lru_t;

  // Position of the order bit for ways i < j
  function automatic int pair_bit(int i, int j);
    return i * WAYS - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  // Mark way w as newer than every other way
  function automatic lru_t lru_touch(lru_t cur, way_t w);
    lru_t n;
    n = cur;
    for (int i = 0; i < WAYS; i++) begin
      for (int j = i + 1; j < WAYS; j++) begin
        if (i == int'(w))      n[pair_bit(i, j)] = 1'b1;
        else if (j == int'(w)) n[pair_bit(i, j)] = 1'b0;
      end
    end
    return n;
  endfunction

  // Way that is older than all others
  function automatic way_t lru_oldest(lru_t cur);
    way_t r;
    logic ok;
    r = '0;
    for (int v = 0; v < WAYS; v++) begin
      ok = 1'b1;
      for (int o = 0; o < WAYS; o++) begin
        if (o != v) begin
          if (v < o) ok = ok & ~cur[pair_bit(v, o)];
          else       ok = ok &  cur[pair_bit(o, v)];
        end
      end
      if (ok) r = way_t'(v);
    end
    return r;
  endfunction
endpackage

// File: rtl/sats_tag_ram.sv
`timescale 1ns/1ps
module sats_tag_ram #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [TAG_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [TAG_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  // No reset: contents only meaningful under a set valid bit
  logic [TAG_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sats_line_state.sv
`timescale 1ns/1ps
module sats_line_state
  import sats_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             set_dirty,
  input  logic [IDX_W-1:0] lk_idx,
  input  way_t             lk_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  way_t             wr_way,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  output logic [WAYS-1:0]  rd_vld,
  output logic [WAYS-1:0]  rd_drt
);
  localparam int SETS = 1 << IDX_W;

  logic [WAYS-1:0] vld_q [SETS];
  logic [WAYS-1:0] drt_q [SETS];

  always_ff @(posedge clk) begin
    if (por_rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
      end
    end else begin
      if (set_dirty) drt_q[lk_idx][lk_way] <= 1'b1;
      // write port last: it wins on the same line
      if (wr_en) begin
        vld_q[wr_idx][wr_way] <= wr_valid;
        drt_q[wr_idx][wr_way] <= wr_dirty;
      end
    end
  end

  assign rd_vld = vld_q[lk_idx];
  assign rd_drt = drt_q[lk_idx];
endmodule

// File: rtl/sats_lru_store.sv
`timescale 1ns/1ps
module sats_lru_store
  import sats_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             lk_touch,
  input  logic [IDX_W-1:0] lk_idx,
  input  way_t             lk_way,
  input  logic             wr_touch,
  input  logic [IDX_W-1:0] wr_idx,
  input  way_t             wr_way,
  output lru_t             lk_row
);
  localparam int SETS = 1 << IDX_W;

  lru_t lru_q [SETS];
  lru_t nxt_lk, base_wr, nxt_wr;

  always_comb begin
    lk_row  = lru_q[lk_idx];
    nxt_lk  = lk_touch ? lru_touch(lk_row, lk_way) : lk_row;
    // chain both updates when they land on one set
    base_wr = (lk_touch && (lk_idx == wr_idx)) ? nxt_lk : lru_q[wr_idx];
    nxt_wr  = lru_touch(base_wr, wr_way);
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      if (lk_touch) lru_q[lk_idx] <= nxt_lk;
      if (wr_touch) lru_q[wr_idx] <= nxt_wr;
    end
  end
endmodule

// File: rtl/setassoc_tag_store.sv
`timescale 1ns/1ps
module setassoc_tag_store
  import sats_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFS_W  = 5,
  parameter int LW_LSB = 2,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 19
) (
  input  logic                    clk,
  input  logic                    por_rst,
  input  logic                    man_rst,
  input  logic                    lk_req,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic [TAG_W-1:0]        lk_ptag,
  input  logic                    lk_store,
  input  logic                    copyback,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_set,
  input  logic [WAY_W-1:0]        wr_way,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic                    wr_valid,
  input  logic                    wr_dirty,
  output logic                    res_valid,
  output logic                    res_hit,
  output logic [WAY_W-1:0]        res_way,
  output logic [WAY_W-1:0]        res_victim,
  output logic                    res_victim_dirty,
  output logic [OFS_W-LW_LSB-1:0] res_lword
);
  localparam int LW_W = OFS_W - LW_LSB;

  logic                 upd_ok, lk_go, lk_hit, wr_go;
  logic [IDX_W-1:0]     lk_idx;
  logic [LW_W-1:0]      lk_lw;
  logic [TAG_W-1:0]     rd_tag [WAYS];
  logic [WAYS-1:0]      lk_vld, lk_drt, hit_vec;
  way_t                 hit_way, vic_way;
  lru_t                 lk_row;

  assign upd_ok = !por_rst && !man_rst;
  assign lk_idx = lk_vaddr[OFS_W+IDX_W-1:OFS_W];
  assign lk_lw  = lk_vaddr[OFS_W-1:LW_LSB];
  assign lk_go  = upd_ok && lk_req;
  assign lk_hit = lk_go && (|hit_vec);
  assign wr_go  = upd_ok && wr_en;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      sats_tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
        .clk   (clk),
        .we    (wr_go && (wr_way == WAY_W'(w))),
        .waddr (wr_set),
        .wdata (wr_tag),
        .raddr (lk_idx),
        .rdata (rd_tag[w])
      );
      assign hit_vec[w] = lk_vld[w] && (rd_tag[w] == lk_ptag);
    end
  endgenerate

  sats_line_state #(.IDX_W(IDX_W)) u_state (
    .clk       (clk),
    .por_rst   (por_rst),
    .set_dirty (lk_hit && lk_store && copyback),
    .lk_idx    (lk_idx),
    .lk_way    (hit_way),
    .wr_en     (wr_go),
    .wr_idx    (wr_set),
    .wr_way    (wr_way),
    .wr_valid  (wr_valid),
    .wr_dirty  (wr_dirty),
    .rd_vld    (lk_vld),
    .rd_drt    (lk_drt)
  );

  sats_lru_store #(.IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .por_rst  (por_rst),
    .lk_touch (lk_hit),
    .lk_idx   (lk_idx),
    .lk_way   (hit_way),
    .wr_touch (wr_go && wr_valid),
    .wr_idx   (wr_set),
    .wr_way   (wr_way),
    .lk_row   (lk_row)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end

  // lowest invalid way overrides the recency choice
  always_comb begin
    vic_way = lru_oldest(lk_row);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!lk_vld[w]) vic_way = way_t'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!upd_ok) begin
      res_valid        <= 1'b0;
      res_hit          <= 1'b0;
      res_way          <= '0;
      res_victim       <= '0;
      res_victim_dirty <= 1'b0;
      res_lword        <= '0;
    end else begin
      res_valid <= lk_req;
      res_hit   <= lk_hit;
      if (lk_req) begin
        res_way          <= hit_way;
        res_victim       <= vic_way;
        res_victim_dirty <= lk_drt[vic_way];
        res_lword        <= lk_lw;
      end
    end
  end
endmodule

// File: rtl/sats_chk.sv
`timescale 1ns/1ps
module sats_chk
  import sats_pkg::*;
#(
  parameter int LW_W = 3
) (
  input logic            clk,
  input logic            por_rst,
  input logic            man_rst,
  input logic            lk_req,
  input logic [LW_W-1:0] lk_lw,
  input logic [WAYS-1:0] hit_vec,
  input logic            res_valid,
  input logic            res_hit,
  input logic [LW_W-1:0] res_lword
);
  p_result_timing_r1: assert property (@(posedge clk) disable iff (por_rst)
    !man_rst |=> (res_valid == $past(lk_req)));

  p_lword_follows_r1: assert property (@(posedge clk) disable iff (por_rst || man_rst)
    lk_req |=> (res_lword == $past(lk_lw)));

  p_hit_has_result_r2: assert property (@(posedge clk) disable iff (por_rst)
    res_hit |-> res_valid);

  p_por_clears_r4: assert property (@(posedge clk)
    por_rst |=> (!res_valid && !res_hit));

  p_manual_clears_r5: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> !res_valid);

  p_single_hit_r11: assert property (@(posedge clk) disable iff (por_rst)
    $onehot0(hit_vec));
endmodule

bind setassoc_tag_store sats_chk #(.LW_W(LW_W)) u_chk (
  .clk       (clk),
  .por_rst   (por_rst),
  .man_rst   (man_rst),
  .lk_req    (lk_req),
  .lk_lw     (lk_lw),
  .hit_vec   (hit_vec),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_lword (res_lword)
);

// File: tb/setassoc_tag_store_tb_top.sv
`timescale 1ns/1ps
module setassoc_tag_store_tb_top;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0;
  logic        lk_req = 1'b0, lk_store = 1'b0, copyback = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [18:0] lk_ptag = '0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_dirty = 1'b0;
  logic [7:0]  wr_set = '0;
  logic [1:0]  wr_way = '0;
  logic [18:0] wr_tag = '0;
  logic        res_valid, res_hit, res_victim_dirty;
  logic [1:0]  res_way, res_victim;
  logic [2:0]  res_lword;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model: tags, flags and recency stamps
  logic [18:0] mt [256][4];
  bit          mv [256][4];
  bit          md [256][4];
  int unsigned ms [256][4];
  int unsigned stamp_cnt;

  always #4 clk = ~clk;

  setassoc_tag_store dut_i (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_ptag(lk_ptag),
    .lk_store(lk_store), .copyback(copyback),
    .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty),
    .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
    .res_victim(res_victim), .res_victim_dirty(res_victim_dirty),
    .res_lword(res_lword)
  );

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic void model_por();
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++) begin
        mv[s][w] = 0; md[s][w] = 0; ms[s][w] = w;
      end
    stamp_cnt = 10;
  endfunction

  function automatic void touch(int s, int w);
    stamp_cnt++;
    ms[s][w] = stamp_cnt;
  endfunction

  function automatic int exp_victim(int s);
    int b;
    for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
    b = 0;
    for (int w = 1; w < 4; w++) if (ms[s][w] < ms[s][b]) b = w;
    return b;
  endfunction

  function automatic logic [31:0] mk_va(int s, int lw);
    logic [31:0] va;
    va = $urandom();
    va[12:5] = s[7:0];
    va[4:2]  = lw[2:0];
    return va;
  endfunction

  // one clock: model predicts from pre-edge state, then updates
  task automatic cycle(string rq_hit, string rq_vic);
    int s, eh, ew, ev, evd, req, lw;
    s = lk_vaddr[12:5]; lw = lk_vaddr[4:2]; req = lk_req;
    eh = 0; ew = 0;
    for (int w = 0; w < 4; w++)
      if (mv[s][w] && mt[s][w] == lk_ptag) begin eh = 1; ew = w; end
    ev = exp_victim(s);
    evd = md[s][ev];
    if (req && eh) begin
      touch(s, ew);
      if (lk_store && copyback) md[s][ew] = 1;
    end
    if (wr_en) begin
      mt[wr_set][wr_way] = wr_tag;
      mv[wr_set][wr_way] = wr_valid;
      md[wr_set][wr_way] = wr_dirty;
      if (wr_valid) touch(wr_set, wr_way);
    end
    @(posedge clk); #1;
    chk("R1", "res_valid", res_valid, req);
    if (req) begin
      chk("R1", "res_lword", res_lword, lw);
      chk(rq_hit, "res_hit", res_hit, eh);
      if (eh) chk(rq_hit, "res_way", res_way, ew);
      chk(rq_vic, "res_victim", res_victim, ev);
      chk(rq_vic, "res_victim_dirty", res_victim_dirty, evd);
    end
    lk_req = 0; wr_en = 0; lk_store = 0;
  endtask

  task automatic look(int s, logic [18:0] t, bit st, bit cb, string rh, string rv);
    lk_req = 1; lk_vaddr = mk_va(s, $urandom() % 8); lk_ptag = t;
    lk_store = st; copyback = cb;
    cycle(rh, rv);
  endtask

  task automatic fill(int s, int w, logic [18:0] t, bit v, bit d);
    wr_en = 1; wr_set = s[7:0]; wr_way = w[1:0]; wr_tag = t;
    wr_valid = v; wr_dirty = d;
    cycle("R8", "R8");
  endtask

  task automatic do_por();
    por_rst = 1;
    model_por();
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R4", "res_valid after power-on reset", res_valid, 0);
    chk("R4", "res_hit after power-on reset", res_hit, 0);
    por_rst = 0;
  endtask

  task automatic history(int s, bit cb);
    for (int w = 0; w < 4; w++) fill(s, w, 19'h100 + w, 1, 0);
    look(s, 19'h101, 1, cb, "R6", "R9");   // store hit on way 1
    look(s, 19'h102, 0, cb, "R9", "R9");
    look(s, 19'h103, 0, cb, "R9", "R9");
    look(s, 19'h100, 0, cb, "R9", "R9");
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    do_por();
    // R4: every line invalid, victim way 0
    look(5, 19'h12345, 0, 0, "R4", "R4");
    // R8 / R2: fill way 2 then hit it
    fill(5, 2, 19'h12345, 1, 0);
    look(5, 19'h12345, 0, 0, "R2", "R10");
    look(5, 19'h54321, 0, 0, "R2", "R10");
    // R9: fill remaining ways; way 2 becomes oldest
    fill(5, 0, 19'h00010, 1, 0);
    fill(5, 1, 19'h00011, 1, 0);
    fill(5, 3, 19'h00013, 1, 0);
    look(5, 19'h7ffff, 0, 0, "R9", "R9");
    look(5, 19'h12345, 0, 0, "R9", "R9");
    look(5, 19'h7ffff, 0, 0, "R9", "R9");
    // R6 vs R7: identical histories, copy-back vs write-through
    history(9, 1);
    look(9, 19'h7ffff, 0, 1, "R6", "R6");
    history(10, 0);
    look(10, 19'h7ffff, 0, 0, "R7", "R7");
    // R5: manual reset keeps state, drops a lookup
    man_rst = 1; lk_req = 1; lk_vaddr = mk_va(9, 3); lk_ptag = 19'h101; lk_store = 1; copyback = 1;
    @(posedge clk); #1;
    chk("R5", "res_valid during manual reset", res_valid, 0);
    man_rst = 0; lk_req = 0; lk_store = 0;
    @(posedge clk); #1;
    chk("R5", "res_valid after manual reset", res_valid, 0);
    look(9, 19'h7ffff, 0, 1, "R5", "R5");
    look(9, 19'h102, 0, 1, "R5", "R5");
    // R12: hit and invalidate the same line in one cycle
    lk_req = 1; lk_vaddr = mk_va(5, 6); lk_ptag = 19'h00010;
    wr_en = 1; wr_set = 8'd5; wr_way = 2'd0; wr_tag = 19'h00010; wr_valid = 0; wr_dirty = 1;
    cycle("R12", "R12");
    look(5, 19'h00010, 0, 0, "R12", "R10");
    // R12: same set, different ways: write-port way ends most recent
    fill(5, 0, 19'h00020, 1, 0);
    lk_req = 1; lk_vaddr = mk_va(5, 1); lk_ptag = 19'h00011;
    wr_en = 1; wr_set = 8'd5; wr_way = 2'd3; wr_tag = 19'h00033; wr_valid = 1; wr_dirty = 0;
    cycle("R12", "R12");
    look(5, 19'h7ffff, 0, 0, "R12", "R9");
    // R3 / R4: power-on reset invalidates but stored tags stay harmless
    do_por();
    look(9, 19'h101, 0, 0, "R3", "R4");
    look(5, 19'h00033, 0, 0, "R3", "R4");

    // random mix over a few sets and a small tag pool
    for (int n = 0; n < 4000; n++) begin
      int r, s, w, k;
      int sets[4] = '{5, 9, 77, 255};
      r = $urandom() % 10;
      if (r < 6 || r == 9) begin
        lk_req = 1; s = sets[$urandom() % 4];
        lk_vaddr = mk_va(s, $urandom() % 8);
        lk_ptag = 19'h40000 + ($urandom() % 5);
        lk_store = $urandom() % 2; copyback = $urandom() % 2;
      end
      if (r >= 6) begin
        s = sets[$urandom() % 4]; w = $urandom() % 4; k = $urandom() % 5;
        wr_en = 1; wr_set = s[7:0]; wr_way = w[1:0];
        wr_tag = 19'h40000 + k; wr_valid = ($urandom() % 4) != 0; wr_dirty = $urandom() % 2;
        for (int o = 0; o < 4; o++)
          if (o != w && mv[s][o] && mt[s][o] == wr_tag) wr_valid = 0;
      end
      cycle("R11", "R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule